// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

An eight-pin general-purpose I/O port with per-pin interrupt detection, programmed over a simple memory-mapped register bus that has an address, write data, read data and separate write and read strobes. Each pin can be an output, driven from a data register under control of a direction register, or an input whose level is brought into the clock domain by a two-flop synchronizer and, if selected for that pin, cleaned by a debounce filter.

Every pin has its own interrupt mode, set by two one-bit controls. One picks level or edge sensing. The other picks the active polarity: low level or falling edge, versus high level or rising edge. Edge events are held until software clears them through a write-one-to-clear end-of-interrupt register. Level events are never held and follow the input directly. An enable register gates every pin. The enabled event bits can be read from a status register and appear both as eight per-pin interrupt outputs and as one combined line, so the port can feed eight dedicated interrupt inputs or one shared input. To catch both edges, software inverts the polarity bit after each event.

Top module: `gpio_irq_port`

## Requirements
- R1: With type1 bit = 1 (edge mode), a change of the pin's qualified level sets its latched event. The change must be 0 to 1 when the type2 bit = 1, and 1 to 0 when the type2 bit = 0.
- R2: With type1 bit = 0 (level mode), the pin's status bit equals the qualified level when type2 = 1 and its inverse when type2 = 0. Nothing is latched, and an end-of-interrupt write has no effect on it.
- R3: A write to end-of-interrupt (0x98) clears the latched event of each pin whose write-data bit is 1 and leaves pins written 0 unchanged. An edge detected in the same cycle as the clear wins, and the event stays set.
- R4: A pin whose enable bit (0x9C) is 0 drives no interrupt and latches no edge. Edges that occur while the pin is disabled are lost, and setting the enable bit later does not raise an interrupt for them.
- R5: A write that changes a pin's type1 or type2 bit clears that pin's latched event. The edge history keeps following the current level, so a disable, reprogram, enable sequence latches no false edge.
- R6: A pin whose debounce bit (0xA8) is 1 takes a new level only after the synchronized input has differed from the accepted level for 16 consecutive ticks, where one tick occurs every DB_DIV clocks. A shorter glitch is ignored. Pins whose debounce bit is 0 bypass the filter.
- R7: Each pad input passes through two flops. A level-mode result is visible 2 clocks after the pad changes, and an edge-mode latched event 3 clocks after.
- R8: irq_pin_o[i] is the enabled status bit of pin i, and irq_o is 1 exactly when any irq_pin_o bit is 1.
- R9: pad_oe_o equals the direction register (0x10; bit = 1 makes the pin an output), and pad_out_o equals the data register (0x00). Reading 0x00 returns the synchronized pad level.
- R10: Register offsets are: data 0x00, direction 0x10, type1 0x90, type2 0x94, end-of-interrupt 0x98, enable 0x9C, status 0xA0 (read only), debounce 0xA8. Reads return the written value for the writable registers; end-of-interrupt and unmapped offsets read 0, and rdata_o is 0 while rd_i is 0.
- R11: After reset all registers, latched events and filter states are 0, and irq_o, irq_pin_o, pad_out_o and pad_oe_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational from addr_i while rd_i is 1 |
| pad_in_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |
| irq_o | output | 1 | Combined interrupt |
| irq_pin_o | output | 8 | Per-pin interrupts |

## Verification
A register write takes effect at the clock edge that samples wr_i, so it shows on the outputs in the next cycle. Read data is combinational and is sampled 1 ns after the inputs are driven. A pad change reaches a level-mode status 2 clocks later and an edge latch 3 clocks later. A debounced pin also waits for its run of 16 divider ticks. The bench's reference model updates on every rising edge with the same register count, and irq_pin_o, irq_o, pad_out_o and pad_oe_o are compared against it at every falling edge. Directed checks then sample the exact cycle before and after each expected change, for latency, glitch rejection, end-of-interrupt collisions and reprogramming.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned AW = 8;
  localparam logic [AW-1:0] OFS_DATA  = 8'h00;
  localparam logic [AW-1:0] OFS_DIR   = 8'h10;
  localparam logic [AW-1:0] OFS_TYPE1 = 8'h90;
  localparam logic [AW-1:0] OFS_TYPE2 = 8'h94;
  localparam logic [AW-1:0] OFS_EOI   = 8'h98;
  localparam logic [AW-1:0] OFS_EN    = 8'h9C;
  localparam logic [AW-1:0] OFS_STAT  = 8'hA0;
  localparam logic [AW-1:0] OFS_DEB   = 8'hA8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int unsigned W      = 8,
  parameter int unsigned DB_DIV = 4,
  parameter int unsigned DB_CNT = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o
);
  localparam int unsigned DW = (DB_DIV > 1) ? $clog2(DB_DIV) : 1;
  localparam int unsigned CW = (DB_CNT > 1) ? $clog2(DB_CNT) : 1;

  logic [DW-1:0] div_q;
  logic          tick;

  assign tick = (div_q == DW'(DB_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= tick ? '0 : div_q + 1'b1;
  end

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        lvl_q <= 1'b0;
      end else if (raw_i[g] == lvl_q) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == CW'(DB_CNT - 1)) begin
          lvl_q <= raw_i[g];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign lvl_o[g] = lvl_q;
  end
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] edge_mode_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] rearm_i,
  output logic [W-1:0] ev_o,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] ev_q, prev_q;

  assign hit_o = en_i & edge_mode_i &
                 ((rise_i & lvl_i & ~prev_q) | (~rise_i & ~lvl_i & prev_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q   <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= lvl_i;
      // mode change wins over a new hit; a new hit wins over a clear
      ev_q   <= ~rearm_i & (hit_o | (ev_q & ~clr_i));
    end
  end

  assign ev_o   = ev_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned DB_DIV = 4,
  parameter int unsigned DB_CNT = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [W-1:0]  rdata_o,
  input  logic [W-1:0]  pad_in_i,
  output logic [W-1:0]  pad_out_o,
  output logic [W-1:0]  pad_oe_o,
  output logic          irq_o,
  output logic [W-1:0]  irq_pin_o
);
  logic [W-1:0] data_q, dir_q, type1_q, type2_q, en_q, deb_q;
  logic [W-1:0] sync_lvl, deb_lvl, filt;
  logic [W-1:0] ev, prev, hit, clr, rearm;
  logic [W-1:0] lvl_stat, stat;

  gpio_sync #(.W(W)) i_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pad_in_i), .q_o(sync_lvl)
  );

  gpio_debounce #(.W(W), .DB_DIV(DB_DIV), .DB_CNT(DB_CNT)) i_deb (
    .clk_i (clk_i), .rst_ni(rst_ni), .raw_i(sync_lvl), .lvl_o(deb_lvl)
  );

  assign filt = (deb_q & deb_lvl) | (~deb_q & sync_lvl);

  always_comb begin
    clr   = '0;
    rearm = '0;
    if (wr_i) begin
      if (addr_i == OFS_EOI)   clr   = wdata_i;
      if (addr_i == OFS_TYPE1) rearm = wdata_i ^ type1_q;
      if (addr_i == OFS_TYPE2) rearm = wdata_i ^ type2_q;
    end
  end

  gpio_edge_latch #(.W(W)) i_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (filt),
    .edge_mode_i(type1_q),
    .rise_i     (type2_q),
    .en_i       (en_q),
    .clr_i      (clr),
    .rearm_i    (rearm),
    .ev_o       (ev),
    .prev_o     (prev),
    .hit_o      (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      dir_q   <= '0;
      type1_q <= '0;
      type2_q <= '0;
      en_q    <= '0;
      deb_q   <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        OFS_DATA:  data_q  <= wdata_i;
        OFS_DIR:   dir_q   <= wdata_i;
        OFS_TYPE1: type1_q <= wdata_i;
        OFS_TYPE2: type2_q <= wdata_i;
        OFS_EN:    en_q    <= wdata_i;
        OFS_DEB:   deb_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign lvl_stat  = (type2_q & filt) | (~type2_q & ~filt);
  assign stat      = en_q & ((type1_q & ev) | (~type1_q & lvl_stat));
  assign irq_pin_o = stat;
  assign irq_o     = |stat;
  assign pad_out_o = data_q;
  assign pad_oe_o  = dir_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        OFS_DATA:  rdata_o = sync_lvl;
        OFS_DIR:   rdata_o = dir_q;
        OFS_TYPE1: rdata_o = type1_q;
        OFS_TYPE2: rdata_o = type2_q;
        OFS_EN:    rdata_o = en_q;
        OFS_STAT:  rdata_o = stat;
        OFS_DEB:   rdata_o = deb_q;
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic [W-1:0]  wdata_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [W-1:0]  rdata_o,
  input logic          irq_o,
  input logic [W-1:0]  irq_pin_o,
  input logic [W-1:0]  en_q,
  input logic [W-1:0]  type1_q,
  input logic [W-1:0]  ev,
  input logic [W-1:0]  prev,
  input logic [W-1:0]  filt,
  input logic [W-1:0]  hit
);
  a_r1_edge_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ev & ~$past(ev) & ~($past(filt) ^ $past(prev))) == '0));

  a_r3_eoi_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_EOI) |=> ((ev & $past(wdata_i) & ~$past(hit)) == '0));

  a_r4_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_pin_o & ~en_q) == '0));

  a_r5_type_change_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_TYPE1) |=> ((ev & ($past(wdata_i) ^ $past(type1_q))) == '0));

  a_r8_combined_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (irq_pin_o != '0));

  a_r10_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .irq_pin_o(irq_pin_o),
  .en_q     (en_q),
  .type1_q  (type1_q),
  .ev       (ev),
  .prev     (prev),
  .filt     (filt),
  .hit      (hit)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;
  localparam int DIV = 4;
  localparam int CNT = 16;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, pad = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] rdata, pad_out, pad_oe, irq_pin;
  logic       irq;

  always #4 clk = ~clk;

  gpio_irq_port #(.W(8), .DB_DIV(DIV), .DB_CNT(CNT)) i_gpio_irq_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rd_i(rd), .rdata_o(rdata), .pad_in_i(pad), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .irq_o(irq), .irq_pin_o(irq_pin)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  bit [7:0] m_sa, m_sb, m_lvl, m_prev, m_ev;
  bit [7:0] m_data, m_dir, m_t1, m_t2, m_en, m_deb;
  int       m_cnt[8];
  int       m_div;

  function automatic bit [7:0] m_filt();
    return (m_deb & m_lvl) | (~m_deb & m_sb);
  endfunction

  function automatic bit [7:0] m_stat();
    bit [7:0] f, lv;
    f  = m_filt();
    lv = (m_t2 & f) | (~m_t2 & ~f);
    return m_en & ((m_t1 & m_ev) | (~m_t1 & lv));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sa = 0; m_sb = 0; m_lvl = 0; m_prev = 0; m_ev = 0;
      m_data = 0; m_dir = 0; m_t1 = 0; m_t2 = 0; m_en = 0; m_deb = 0;
      m_div = 0;
      for (int i = 0; i < 8; i++) m_cnt[i] = 0;
    end else begin
      bit [7:0] f, hit, chg, eoi;
      bit tick;
      f    = m_filt();
      tick = (m_div == DIV - 1);
      hit  = m_en & m_t1 & ((m_t2 & f & ~m_prev) | (~m_t2 & ~f & m_prev));
      chg  = 0; eoi = 0;
      if (wr && addr == 8'h90) chg = wdata ^ m_t1;
      if (wr && addr == 8'h94) chg = wdata ^ m_t2;
      if (wr && addr == 8'h98) eoi = wdata;
      m_ev   = ~chg & (hit | (m_ev & ~eoi));
      m_prev = f;
      for (int i = 0; i < 8; i++) begin
        if (m_sb[i] == m_lvl[i]) m_cnt[i] = 0;
        else if (tick) begin
          if (m_cnt[i] == CNT - 1) begin m_lvl[i] = m_sb[i]; m_cnt[i] = 0; end
          else m_cnt[i]++;
        end
      end
      m_div = tick ? 0 : m_div + 1;
      m_sb = m_sa; m_sa = pad;
      if (wr) begin
        case (addr)
          8'h00: m_data = wdata;
          8'h10: m_dir  = wdata;
          8'h90: m_t1   = wdata;
          8'h94: m_t2   = wdata;
          8'h9C: m_en   = wdata;
          8'hA8: m_deb  = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison of register-driven outputs
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R8 irq_pin_o", irq_pin, m_stat());
      check("R8 irq_o", {7'b0, irq}, {7'b0, |m_stat()});
      check("R9 pad_out_o", pad_out, m_data);
      check("R9 pad_oe_o", pad_oe, m_dir);
    end
  end

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1; rd = 0;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    addr = a; rd = 1;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    // R11 reset state
    check("R11 irq_o at reset", {7'b0, irq}, 8'h00);
    check("R11 irq_pin_o at reset", irq_pin, 8'h00);
    check("R11 pad_oe_o at reset", pad_oe, 8'h00);
    check("R10 idle rdata", rdata, 8'h00);
    rst_n = 1;
    cyc(2);
    rd_chk("R11 dir reset", 8'h10, 8'h00);
    rd_chk("R11 type1 reset", 8'h90, 8'h00);
    rd_chk("R11 enable reset", 8'h9C, 8'h00);
    rd_chk("R11 status reset", 8'hA0, 8'h00);

    // R9 / R10 outputs and readback
    wr_reg(8'h00, 8'hA5);
    wr_reg(8'h10, 8'h0F);
    check("R9 pad_out_o", pad_out, 8'hA5);
    check("R9 pad_oe_o", pad_oe, 8'h0F);
    rd_chk("R10 dir readback", 8'h10, 8'h0F);
    wr_reg(8'hA8, 8'h20);
    rd_chk("R10 debounce readback", 8'hA8, 8'h20);
    wr_reg(8'hA8, 8'h00);
    rd_chk("R10 eoi reads zero", 8'h98, 8'h00);
    rd_chk("R10 unmapped reads zero", 8'h44, 8'h00);
    pad = 8'h3C;
    cyc(3);
    rd_chk("R9 data reads synced pad", 8'h00, 8'h3C);
    pad = 8'h00;
    cyc(3);
    wr_reg(8'h10, 8'h00);

    // R7 latency: pin0 level-high enabled
    wr_reg(8'h94, 8'h01);
    wr_reg(8'h9C, 8'h01);
    pad[0] = 1;
    @(negedge clk); check("R7 level after 1 clk", irq_pin, 8'h00);
    @(negedge clk); check("R7 level after 2 clk", irq_pin, 8'h01);
    pad[0] = 0;
    cyc(3);
    check("R2 level follows input", irq_pin, 8'h00);

    // R1 rising edge on pin1, R3 clear
    wr_reg(8'h9C, 8'h00);
    wr_reg(8'h90, 8'h02);
    wr_reg(8'h94, 8'h02);
    wr_reg(8'h9C, 8'h02);
    check("R5 no false edge after reprogram", irq_pin, 8'h00);
    pad[1] = 1;
    cyc(2); check("R7 edge not yet at 2 clk", irq_pin, 8'h00);
    cyc(1); check("R1 rising edge latched at 3 clk", irq_pin, 8'h02);
    pad[1] = 0;
    cyc(4);
    check("R1 latch holds after input falls", irq_pin, 8'h02);
    wr_reg(8'h98, 8'hFD);
    check("R3 eoi with bit 0 leaves pin", irq_pin, 8'h02);
    wr_reg(8'h98, 8'h02);
    check("R3 eoi clears pin", irq_pin, 8'h00);
    rd_chk("R10 status after clear", 8'hA0, 8'h00);

    // R3 clear collides with a new edge: edge wins
    pad[1] = 1;
    cyc(1);
    // edge detected at the 3rd posedge; place the eoi strobe there
    @(negedge clk); addr = 8'h98; wdata = 8'h02; wr = 1;
    @(negedge clk); wr = 0;
    check("R3 same-cycle edge wins over eoi", irq_pin, 8'h02);
    wr_reg(8'h98, 8'h02);
    pad[1] = 0;
    cyc(4);

    // R1 falling edge on pin2
    wr_reg(8'h90, 8'h06);
    pad[2] = 1;
    cyc(4);
    wr_reg(8'h9C, 8'h06);
    check("R1 rise ignored in falling mode", irq_pin, 8'h00);
    pad[2] = 0;
    cyc(4);
    check("R1 falling edge latched", irq_pin, 8'h04);

    // R5 polarity change clears latch
    wr_reg(8'h94, 8'h06);
    check("R5 type2 change clears latch", irq_pin, 8'h00);

    // R2 level low on pin3, eoi no effect
    wr_reg(8'h9C, 8'h08);
    check("R2 level-low active with pin low", irq_pin, 8'h08);
    wr_reg(8'h98, 8'hFF);
    check("R2 eoi no effect on level pin", irq_pin, 8'h08);
    pad[3] = 1;
    cyc(3);
    check("R2 level-low released", irq_pin, 8'h00);

    // R4 disabled pin4 edge discarded
    wr_reg(8'h9C, 8'h00);
    wr_reg(8'h90, 8'h16);
    wr_reg(8'h94, 8'h16);
    pad[4] = 1;
    cyc(4);
    check("R4 disabled pin silent", irq_pin, 8'h00);
    wr_reg(8'h9C, 8'h10);
    cyc(2);
    check("R4 edge while disabled lost", irq_pin, 8'h00);

    // R6 debounce on pin5, level-high
    wr_reg(8'h9C, 8'h00);
    wr_reg(8'h90, 8'h00);
    wr_reg(8'h94, 8'h20);
    wr_reg(8'hA8, 8'h20);
    wr_reg(8'h9C, 8'h20);
    pad[5] = 1;
    cyc(20);
    pad[5] = 0;
    cyc(80);
    check("R6 short glitch rejected", irq_pin, 8'h00);
    pad[5] = 1;
    cyc(40);
    check("R6 not accepted before 16 ticks", irq_pin, 8'h00);
    cyc(40);
    check("R6 accepted after stable run", irq_pin, 8'h20);
    wr_reg(8'hA8, 8'h00);

    // random traffic compared every cycle against the model (R1-R9 paths)
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ofs[8] = '{8'h00, 8'h10, 8'h90, 8'h94, 8'h98, 8'h9C, 8'hA0, 8'hA8};
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) pad = pad ^ (8'd1 << $urandom_range(0, 7));
      wr = ($urandom_range(0, 5) == 0);
      addr = ofs[$urandom_range(0, 7)];
      wdata = $urandom_range(0, 255);
      rd = 1;
      #1;
      case (addr)
        8'h00: check("R9 random data read", rdata, m_sb);
        8'hA0: check("R10 random status read", rdata, m_stat());
        8'h9C: check("R10 random enable read", rdata, m_en);
        default: ;
      endcase
    end
    @(negedge clk); wr = 0; rd = 0;
    cyc(2);
    finish_run();
  end
endmodule